// File: doc/BRIEF.md
# Multidrop Test-Bus Address Selection Controller

This block decides whether one scan bridge on a shared, multidrop test bus is currently being addressed by the test master. It watches the bridge's own TAP controller (a Test-Logic-Reset flag, an Update-IR strobe and a shift flag) together with the parallel instruction register value. At each Update-IR it classifies the low address bits of that value against the board's static slot pins, a broadcast code, an interrogation code, a reserved all-zero code and a set of multicast group codes.

The outcome is one of four states: waiting for an address, selected alone, selected as part of a group (broadcast or multicast), or unselected. The state gates the decode of later instructions, decides when the backplane TDO driver may be enabled, and marks the device-identification register as the active data register immediately after selection. A small multicast group register, writable only while the device is selected alone and the group-register instruction is loaded, fixes which multicast code this device answers.

Top module: `mdsel_ctrl`

## Requirements
- R1: Asserting rst_n low (asynchronous) puts the block in the waiting state (sel_state = 0) and clears the multicast group register to group 0; a high tap_tlr at a clock edge also returns the block to the waiting state but keeps the group register.
- R2: In the waiting state, an Update-IR whose low ADDR_W bits equal slot_id (and are not a reserved code) moves the block to selected-alone (sel_state = 1, sel_single = 1).
- R3: In the waiting state, address code 0x3B moves the block to group-selected (sel_state = 2, sel_group = 1) whatever the slot pins and group register hold.
- R4: In the waiting state, code 0x3C + g selects the group state only when the group register holds g (g = 0..3); on any other group value the block goes unselected (sel_state = 3).
- R5: Codes 0x00 and 0x3A never select the device, even when slot_id equals them; they lead to the unselected state.
- R6: Any other address not equal to slot_id leads to the unselected state, and an unselected block ignores every instruction load except opcode 0xC3 (including its own slot address).
- R7: An Update-IR with the full opcode 0xC3 returns the block to the waiting state from the selected-alone, group-selected and unselected states.
- R8: Instruction bits above the low ADDR_W bits are ignored during address matching.
- R9: tdo_oe is high only while the block is selected alone and tap_shift is high; it stays low in the waiting, group-selected and unselected states.
- R10: l2_en is high exactly in the selected-alone and group-selected states.
- R11: The group register takes grp_din on a clock edge with grp_wr high only when the block is selected alone and the last instruction loaded there was opcode 0x03; otherwise grp_wr is ignored.
- R12: dr_id_sel rises on the edge that selects the device and falls on the next Update-IR or on leaving the selected states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test reset |
| tap_tlr | input | 1 | TAP is in Test-Logic-Reset |
| tap_upd_ir | input | 1 | TAP is in Update-IR this cycle |
| tap_shift | input | 1 | TAP is in a shift state |
| ir_val | input | IR_W | Parallel instruction register value |
| slot_id | input | ADDR_W | Static slot address pins |
| grp_wr | input | 1 | Update-DR strobe for the group register |
| grp_din | input | GRP_W | Value scanned for the group register |
| sel_state | output | 2 | 0 waiting, 1 selected alone, 2 group-selected, 3 unselected |
| sel_single | output | 1 | Selected alone |
| sel_group | output | 1 | Selected by broadcast or multicast |
| l2_en | output | 1 | Enables decode of follow-on instructions |
| tdo_oe | output | 1 | Backplane TDO driver enable |
| dr_id_sel | output | 1 | Identification register is the active data register |

## Verification
Addressing is tried with the exact slot code, the same code with the top instruction bit set, the broadcast code, a multicast code that matches the group register and one that does not, the two reserved codes with the slot pins set equal to them, and an unrelated code; these tell apart slot matching, reserved-code priority, group filtering and masking of high bits. Follow-on loads of the slot code in the unselected and group states, and of 0xC3 in each non-waiting state, separate sticky states from the return path. Group-register writes with and without the group instruction loaded, and after a mid-run reset, show through later multicast outcomes whether the write was taken.

// File: rtl/mdsel_pkg.sv
package mdsel_pkg;

  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_SINGLE = 2'd1,
    ST_GROUP  = 2'd2,
    ST_UNSEL  = 2'd3
  } sel_st_e;

  typedef enum logic [1:0] {
    VD_SINGLE = 2'd0,
    VD_GROUP  = 2'd1,
    VD_UNSEL  = 2'd2
  } verdict_e;

  localparam int unsigned CODE_RSVD     = 32'h00;
  localparam int unsigned CODE_INTERROG = 32'h3A;
  localparam int unsigned CODE_BCAST    = 32'h3B;
  localparam int unsigned CODE_MCAST0   = 32'h3C;
  localparam int unsigned OP_GOTOWAIT   = 32'hC3;
  localparam int unsigned OP_GRPSEL     = 32'h03;

endpackage

// File: rtl/mdsel_rst_sync.sv
module mdsel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_int_n = sync_q;
endmodule

// File: rtl/mdsel_addr_match.sv
module mdsel_addr_match
  import mdsel_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int GRP_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] slot_id,
  input  logic [GRP_W-1:0]  grp_q,
  output verdict_e          verdict
);
  localparam int N_GRP = 1 << GRP_W;

  logic [N_GRP-1:0] mc_code;
  logic [N_GRP-1:0] mc_mine;
  logic             is_bcast;
  logic             is_rsvd;

  for (genvar g = 0; g < N_GRP; g++) begin : g_mcast
    assign mc_code[g] = (addr == ADDR_W'(CODE_MCAST0 + g));
    assign mc_mine[g] = mc_code[g] && (grp_q == GRP_W'(g));
  end

  assign is_bcast = (addr == ADDR_W'(CODE_BCAST));
  assign is_rsvd  = (addr == ADDR_W'(CODE_RSVD)) || (addr == ADDR_W'(CODE_INTERROG));

  always_comb begin
    if (is_bcast || (|mc_mine)) begin
      verdict = VD_GROUP;
    end else if (is_rsvd || (|mc_code)) begin
      verdict = VD_UNSEL;
    end else if (addr == slot_id) begin
      verdict = VD_SINGLE;
    end else begin
      verdict = VD_UNSEL;
    end
  end
endmodule

// File: rtl/mdsel_grp_reg.sv
module mdsel_grp_reg #(
  parameter int GRP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tap_tlr,
  input  logic             tap_upd_ir,
  input  logic             ir_is_grpsel,
  input  logic             in_single,
  input  logic             grp_wr,
  input  logic [GRP_W-1:0] grp_din,
  output logic [GRP_W-1:0] grp_q
);
  logic grpsel_q;
  logic grpsel_d;
  logic grp_en;

  always_comb begin
    grpsel_d = grpsel_q;
    if (tap_tlr) begin
      grpsel_d = 1'b0;
    end else if (tap_upd_ir) begin
      grpsel_d = in_single && ir_is_grpsel;
    end
  end

  assign grp_en = grp_wr && in_single && grpsel_q && !tap_upd_ir && !tap_tlr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grpsel_q <= 1'b0;
    end else begin
      grpsel_q <= grpsel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
    end else if (grp_en) begin
      grp_q <= grp_din;
    end
  end
endmodule

// File: rtl/mdsel_fsm.sv
module mdsel_fsm
  import mdsel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tap_tlr,
  input  logic     tap_upd_ir,
  input  logic     is_gotowait,
  input  verdict_e verdict,
  output sel_st_e  state_q,
  output logic     id_q
);
  sel_st_e state_d;
  logic    id_d;

  always_comb begin
    state_d = state_q;
    id_d    = id_q;
    if (tap_tlr) begin
      state_d = ST_WAIT;
      id_d    = 1'b0;
    end else if (tap_upd_ir) begin
      id_d = 1'b0;
      if (state_q == ST_WAIT) begin
        unique case (verdict)
          VD_SINGLE: begin state_d = ST_SINGLE; id_d = 1'b1; end
          VD_GROUP:  begin state_d = ST_GROUP;  id_d = 1'b1; end
          default:   state_d = ST_UNSEL;
        endcase
      end else if (is_gotowait) begin
        state_d = ST_WAIT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      id_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      id_q    <= id_d;
    end
  end
endmodule

// File: rtl/mdsel_ctrl.sv
module mdsel_ctrl
  import mdsel_pkg::*;
#(
  parameter int IR_W   = 8,
  parameter int ADDR_W = 7,
  parameter int GRP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tap_tlr,
  input  logic              tap_upd_ir,
  input  logic              tap_shift,
  input  logic [IR_W-1:0]   ir_val,
  input  logic [ADDR_W-1:0] slot_id,
  input  logic              grp_wr,
  input  logic [GRP_W-1:0]  grp_din,
  output logic [1:0]        sel_state,
  output logic              sel_single,
  output logic              sel_group,
  output logic              l2_en,
  output logic              tdo_oe,
  output logic              dr_id_sel
);
  logic             rst_int_n;
  logic [GRP_W-1:0] grp_q;
  verdict_e         verdict;
  sel_st_e          state_q;
  logic             id_q;
  logic             is_gotowait;
  logic             is_grpsel;

  assign is_gotowait = (ir_val == IR_W'(OP_GOTOWAIT));
  assign is_grpsel   = (ir_val == IR_W'(OP_GRPSEL));

  mdsel_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  mdsel_addr_match #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_match (
    .addr    (ir_val[ADDR_W-1:0]),
    .slot_id (slot_id),
    .grp_q   (grp_q),
    .verdict (verdict)
  );

  mdsel_grp_reg #(.GRP_W(GRP_W)) u_grp (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .tap_tlr      (tap_tlr),
    .tap_upd_ir   (tap_upd_ir),
    .ir_is_grpsel (is_grpsel),
    .in_single    (state_q == ST_SINGLE),
    .grp_wr       (grp_wr),
    .grp_din      (grp_din),
    .grp_q        (grp_q)
  );

  mdsel_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tap_tlr     (tap_tlr),
    .tap_upd_ir  (tap_upd_ir),
    .is_gotowait (is_gotowait),
    .verdict     (verdict),
    .state_q     (state_q),
    .id_q        (id_q)
  );

  assign sel_state  = state_q;
  assign sel_single = (state_q == ST_SINGLE);
  assign sel_group  = (state_q == ST_GROUP);
  assign l2_en      = sel_single || sel_group;
  assign tdo_oe     = sel_single && tap_shift;
  assign dr_id_sel  = id_q;
endmodule

// File: rtl/mdsel_ctrl_chk.sv
module mdsel_ctrl_chk #(
  parameter int IR_W   = 8,
  parameter int ADDR_W = 7,
  parameter int GRP_W  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tap_tlr,
  input logic            tap_upd_ir,
  input logic [IR_W-1:0] ir_val,
  input logic [1:0]      sel_state,
  input logic            sel_single,
  input logic            sel_group,
  input logic            l2_en,
  input logic            tdo_oe,
  input logic            dr_id_sel
);
  logic [1:0] rel_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_cnt <= 2'd0;
    end else if (rel_cnt != 2'd2) begin
      rel_cnt <= rel_cnt + 2'd1;
    end
  end

  a_r1_tlr_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
    tap_tlr |=> (sel_state == 2'd0));

  a_r5_zero_never_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_cnt == 2'd2 && sel_state == 2'd0 && tap_upd_ir && !tap_tlr &&
     ir_val[ADDR_W-1:0] == '0) |=> (sel_state == 2'd3));

  a_r6_unsel_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_state == 2'd3 && !tap_tlr && !(tap_upd_ir && ir_val == IR_W'(8'hC3)))
      |=> (sel_state == 2'd3));

  a_r7_gotowait_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_state != 2'd0 && tap_upd_ir && ir_val == IR_W'(8'hC3))
      |=> (sel_state == 2'd0));

  a_r9_tdo_only_single: assert property (@(posedge clk) disable iff (!rst_n)
    tdo_oe |-> (sel_single && sel_state == 2'd1));

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_single && sel_group) && (l2_en == (sel_state == 2'd1 || sel_state == 2'd2)));

  a_r12_id_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    dr_id_sel |-> l2_en);

  a_r12_id_drops_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_en && tap_upd_ir) |=> !dr_id_sel);
endmodule

bind mdsel_ctrl mdsel_ctrl_chk #(.IR_W(IR_W), .ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tap_tlr    (tap_tlr),
  .tap_upd_ir (tap_upd_ir),
  .ir_val     (ir_val),
  .sel_state  (sel_state),
  .sel_single (sel_single),
  .sel_group  (sel_group),
  .l2_en      (l2_en),
  .tdo_oe     (tdo_oe),
  .dr_id_sel  (dr_id_sel)
);

// File: tb/mdsel_ctrl_tb.sv
module mdsel_ctrl_tb_top;
  logic       clk;
  logic       rst_n;
  logic       tap_tlr;
  logic       tap_upd_ir;
  logic       tap_shift;
  logic [7:0] ir_val;
  logic [6:0] slot_id;
  logic       grp_wr;
  logic [1:0] grp_din;
  logic [1:0] sel_state;
  logic       sel_single;
  logic       sel_group;
  logic       l2_en;
  logic       tdo_oe;
  logic       dr_id_sel;

  int n_tests;
  int n_fail;
  string cur_req;

  // behavioural reference
  int m_st;
  int m_grp;
  int m_gs;
  int m_id;
  int m_hold;

  mdsel_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tap_tlr(tap_tlr), .tap_upd_ir(tap_upd_ir),
    .tap_shift(tap_shift), .ir_val(ir_val), .slot_id(slot_id), .grp_wr(grp_wr),
    .grp_din(grp_din), .sel_state(sel_state), .sel_single(sel_single),
    .sel_group(sel_group), .l2_en(l2_en), .tdo_oe(tdo_oe), .dr_id_sel(dr_id_sel)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int a;
    int ns;
    if (!rst_n) begin
      m_st = 0; m_grp = 0; m_gs = 0; m_id = 0; m_hold = 2;
    end else if (m_hold > 0) begin
      m_hold--;
    end else if (tap_tlr) begin
      m_st = 0; m_gs = 0; m_id = 0;
    end else if (tap_upd_ir) begin
      a = int'(ir_val) % 128;
      if (m_st == 0) begin
        if (a == 'h3B) ns = 2;
        else if (a >= 'h3C && a <= 'h3F) ns = ((a - 'h3C) == m_grp) ? 2 : 3;
        else if (a == 0 || a == 'h3A) ns = 3;
        else if (a == int'(slot_id)) ns = 1;
        else ns = 3;
        m_id = (ns == 1 || ns == 2) ? 1 : 0;
      end else begin
        ns = (ir_val == 8'hC3) ? 0 : m_st;
        m_id = 0;
      end
      m_gs = (m_st == 1 && ir_val == 8'h03) ? 1 : 0;
      m_st = ns;
    end else if (grp_wr && m_st == 1 && m_gs == 1) begin
      m_grp = int'(grp_din);
    end
  endtask

  task automatic compare_all();
    chk("sel_state", int'(sel_state), m_st);
    chk("sel_single", int'(sel_single), (m_st == 1) ? 1 : 0);
    chk("sel_group", int'(sel_group), (m_st == 2) ? 1 : 0);
    chk("l2_en", int'(l2_en), (m_st == 1 || m_st == 2) ? 1 : 0);            // R10
    chk("tdo_oe", int'(tdo_oe), (m_st == 1 && tap_shift) ? 1 : 0);           // R9
    chk("dr_id_sel", int'(dr_id_sel), m_id);                                  // R12
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(int n);
    tap_tlr = 0; tap_upd_ir = 0; grp_wr = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic load_ir(logic [7:0] v);
    ir_val = v; tap_upd_ir = 1;
    tick();
    tap_upd_ir = 0;
    tick();
  endtask

  task automatic expect_state(int s);
    chk("explicit state", int'(sel_state), s);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    m_st = 0; m_grp = 0; m_gs = 0; m_id = 0; m_hold = 2;
    #1;
    compare_all();
    tick();
    rst_n = 1;
    idle(3);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1; tap_tlr = 0; tap_upd_ir = 0; tap_shift = 0;
    ir_val = '0; slot_id = 7'h15; grp_wr = 0; grp_din = '0;
    m_st = 0; m_grp = 0; m_gs = 0; m_id = 0; m_hold = 2;

    cur_req = "R1";
    do_reset();
    expect_state(0);

    cur_req = "R2";                      // exact slot, then ID register marked (R12)
    load_ir(8'h15); expect_state(1);
    chk("R12 id after select", int'(dr_id_sel), 1);
    cur_req = "R9";
    tap_shift = 1; idle(2); chk("R9 tdo single", int'(tdo_oe), 1); tap_shift = 0;

    cur_req = "R11";                     // group instruction loaded, write group 2
    load_ir(8'h03);
    chk("R12 id dropped", int'(dr_id_sel), 0);
    grp_din = 2'd2; grp_wr = 1; tick(); grp_wr = 0; idle(1);
    cur_req = "R7";
    load_ir(8'hC3); expect_state(0);

    cur_req = "R4";
    load_ir(8'h3E); expect_state(2);
    cur_req = "R9";
    tap_shift = 1; idle(2); chk("R9 tdo group", int'(tdo_oe), 0); tap_shift = 0;
    cur_req = "R6";
    load_ir(8'h15); expect_state(2);
    cur_req = "R7";
    load_ir(8'hC3); expect_state(0);

    cur_req = "R4";
    load_ir(8'h3D); expect_state(3);
    cur_req = "R6";
    tap_shift = 1; load_ir(8'h15); expect_state(3);
    chk("R9 tdo unsel", int'(tdo_oe), 0); tap_shift = 0;
    cur_req = "R7";
    load_ir(8'hC3); expect_state(0);

    cur_req = "R3";
    load_ir(8'h3B); expect_state(2);
    cur_req = "R1";
    tap_tlr = 1; tick(); tap_tlr = 0; idle(1); expect_state(0);

    cur_req = "R8";
    load_ir(8'h95); expect_state(1);

    cur_req = "R11";                     // write without group instruction: ignored
    load_ir(8'hAA);
    grp_din = 2'd1; grp_wr = 1; tick(); grp_wr = 0; idle(1);
    load_ir(8'hC3);
    load_ir(8'h3D); expect_state(3);     // still group 2
    load_ir(8'hC3);
    load_ir(8'h3E); expect_state(2);
    load_ir(8'hC3);

    cur_req = "R11";                     // write while not selected alone: ignored
    grp_din = 2'd3; grp_wr = 1; tick(); grp_wr = 0; idle(1);
    load_ir(8'h3F); expect_state(3);
    load_ir(8'hC3);

    cur_req = "R5";
    slot_id = 7'h3A; load_ir(8'h3A); expect_state(3);
    load_ir(8'hC3);
    slot_id = 7'h00; load_ir(8'h80); expect_state(3);
    load_ir(8'hC3);
    slot_id = 7'h15;

    cur_req = "R6";
    load_ir(8'h22); expect_state(3);
    load_ir(8'hC3);

    cur_req = "R1";                      // mid-run reset clears group to 0
    do_reset();
    load_ir(8'h3E); expect_state(3);
    load_ir(8'hC3);
    load_ir(8'h3C); expect_state(2);
    tap_tlr = 1; tick(); tap_tlr = 0; idle(1);

    cur_req = "R4";                      // TLR keeps the group register
    load_ir(8'h15); load_ir(8'h03);
    grp_din = 2'd1; grp_wr = 1; tick(); grp_wr = 0; idle(1);
    tap_tlr = 1; tick(); tap_tlr = 0; idle(1);
    load_ir(8'h3D); expect_state(2);
    cur_req = "R10";
    chk("R10 l2 group", int'(l2_en), 1);
    idle(3);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule